// File: doc/BRIEF.md
# Four-Slot Transmit Descriptor Engine

This block queues outgoing frames through four descriptor slots. Each slot holds a buffer base address and a command/status word. Software fills the address first. It then writes the command word, which carries the frame length and an early-start threshold. That write arms the slot.

An idle scanner visits the slots in a fixed circular order. When it finds an armed slot, the engine reads the frame one byte at a time through a request/grant memory port into a small byte FIFO. It begins to offer bytes on a valid/ready stream toward the MAC once enough bytes are buffered. The engine records progress in the slot's status word and raises sticky interrupt flags for good completion and for underrun.

The engine adds no padding. The caller supplies at least 60 bytes, and the MAC appends the frame check sequence. Buffers are expected to be contiguous and 4-byte aligned; the engine itself simply walks byte addresses from the base.

Top module: `txdesc_engine`

## Requirements
- R1: After reset, every slot status word reads 0x0000_2000 (host-owns set), every address word reads 0, the interrupt word reads 0, `irq` is low, and neither `tx_valid` nor `mem_req` is asserted.
- R2: The register map is as follows. Slot i status is at byte offset 4*i, slot i address is at 0x10+4*i, and the interrupt word is at 0x20. A status write takes the length from bits 12:0 and the threshold from bits 21:16, clears bits 13, 14 and 15, and arms the slot. Reads return the stored length and threshold in those same bit positions, and the stored address in full.
- R3: Byte k of the active frame (k = 0..length-1) is read from address base+k, in order. Exactly one byte is taken per cycle in which `mem_req` and `mem_gnt` are both high, and no more than FIFO_DEPTH bytes are ever buffered.
- R4: The first `tx_valid` of a frame appears only after the buffered count has reached T = max(1, min(32*threshold, FIFO_DEPTH)), or after the whole frame has been fetched. With grants every cycle, it appears in the cycle after that condition is met.
- R5: Bytes leave in buffer order, with `tx_last` high on the final one. While `tx_valid` is high and `tx_ready` is low, `tx_valid`, `tx_data` and `tx_last` hold.
- R6: Status bit 13 (host-owns) becomes 1 when the last byte of the frame has been fetched, even if the MAC has not yet taken it.
- R7: When the MAC accepts the final byte, status bit 15 (OK) sets, and interrupt bit 2 sets.
- R8: If `tx_ready` is high while the FIFO is empty in mid-frame, the engine does three things. It sets status bit 14 (underrun) and interrupt bit 3, leaves bit 15 clear, and drops the rest of the frame. Bit 13 stays 0 if the frame was not fully fetched.
- R9: Slots are served in the order 0,1,2,3,0,…, with the pointer stepping once after every finished or dropped frame. Slots that are not armed are passed over.
- R10: A status write to the slot currently being sent has no effect.
- R11: Writing 1 to interrupt bits 2 or 3 clears them. `irq` is high whenever either bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte address (write and read) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| irq | output | 1 | Any interrupt flag set |
| mem_req | output | 1 | Byte fetch request |
| mem_addr | output | 32 | Byte fetch address |
| mem_gnt | input | 1 | Fetch grant; data valid in the same cycle |
| mem_rdata | input | 8 | Fetched byte |
| tx_valid | output | 1 | Byte offered to the MAC |
| tx_data | output | 8 | Byte to the MAC |
| tx_last | output | 1 | Final byte of the frame |
| tx_ready | input | 1 | MAC takes the byte this cycle |

## Verification
The assertions rely on three properties of the inputs. `mem_rdata` must be valid in the same cycle as `mem_gnt`. The MAC must not need the stream to wait for it; it may raise `tx_ready` whenever it likes. Software must program the address word before arming a slot, and must give a non-zero length. The bench keeps within these limits: memory data is a pure function of the address, grants and ready are driven from fixed per-test patterns, and every arming write comes after its address write. Underrun is provoked on purpose by granting only one cycle in four against an always-ready MAC.

// File: rtl/txd_pkg.sv
package txd_pkg;

  localparam int LEN_W    = 13;
  localparam int TH_W     = 6;
  localparam int OK_IBIT  = 2;
  localparam int ERR_IBIT = 3;

  // Field order matches the status word bits 21:0.
  typedef struct packed {
    logic [TH_W-1:0]  th;
    logic             ok;
    logic             unr;
    logic             own;
    logic [LEN_W-1:0] len;
  } slot_st_t;

  function automatic logic [31:0] pack_status(input slot_st_t s);
    return {10'b0, s};
  endfunction

  // Buffered byte count that releases the stream.
  function automatic logic [15:0] eff_thresh(input logic [TH_W-1:0] th,
                                             input int unsigned depth);
    int unsigned t;
    t = {21'b0, th, 5'b0};
    if (t > depth) t = depth;
    if (t == 0) t = 1;
    return 16'(t);
  endfunction

endpackage

// File: rtl/txd_fifo.sv
module txd_fifo #(
  parameter int DEPTH = 64,
  parameter int W     = 8,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = PTR_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic             pop,
  input  logic             flush,
  input  logic [W-1:0]     din,
  output logic [W-1:0]     dout,
  output logic [CNT_W-1:0] count,
  output logic             empty,
  output logic             full
);

  logic [W-1:0]     mem_q [DEPTH];
  logic [PTR_W-1:0] wp_q, rp_q;
  logic [CNT_W-1:0] cnt_q;

  assign count = cnt_q;
  assign empty = (cnt_q == '0);
  assign full  = (cnt_q == CNT_W'(DEPTH));
  assign dout  = mem_q[rp_q];

  always_ff @(posedge clk) begin
    if (push) mem_q[wp_q] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else if (flush) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push) wp_q <= wp_q + 1'b1;
      if (pop)  rp_q <= rp_q + 1'b1;
      case ({push, pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  // R3: never write into a full buffer
  a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full);
  // R8: never read an empty buffer
  a_r8_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);

endmodule

// File: rtl/txd_regs.sv
module txd_regs
  import txd_pkg::*;
#(
  parameter int NSLOT = 4,
  parameter int AW    = 8,
  localparam int SB   = (NSLOT > 1) ? $clog2(NSLOT) : 1
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        reg_wr,
  input  logic [AW-1:0]               reg_addr,
  input  logic [31:0]                 reg_wdata,
  output logic [31:0]                 reg_rdata,
  output logic                        irq,
  input  logic                        lock,
  input  logic [SB-1:0]               lock_slot,
  input  logic                        ev_start,
  input  logic                        ev_fetched,
  input  logic                        ev_ok,
  input  logic                        ev_unr,
  output logic [NSLOT-1:0]            pend_o,
  output logic [NSLOT-1:0][LEN_W-1:0] len_o,
  output logic [NSLOT-1:0][TH_W-1:0]  th_o,
  output logic [NSLOT-1:0][31:0]      base_o
);

  localparam logic [AW-1:0] ST_BASE = AW'('h00);
  localparam logic [AW-1:0] AD_BASE = AW'('h10);
  localparam logic [AW-1:0] IR_ADDR = AW'('h20);
  localparam int HI = 2 + SB;

  logic          st_hit, ad_hit, ir_hit;
  logic [SB-1:0] idx;
  logic          unused_wbits;

  assign idx    = reg_addr[HI-1:2];
  assign st_hit = (reg_addr[AW-1:HI] == ST_BASE[AW-1:HI]) && (reg_addr[1:0] == 2'b00);
  assign ad_hit = (reg_addr[AW-1:HI] == AD_BASE[AW-1:HI]) && (reg_addr[1:0] == 2'b00);
  assign ir_hit = (reg_addr == IR_ADDR);
  assign unused_wbits = ^{reg_wdata[31:22], reg_wdata[15:13]};

  slot_st_t    st_w   [NSLOT];
  logic [31:0] base_w [NSLOT];

  for (genvar i = 0; i < NSLOT; i++) begin : g_slot
    slot_st_t    st_q;
    logic [31:0] base_q;
    logic        pend_q;
    logic        me, wr_me, blocked;

    assign me      = (lock_slot == SB'(i));
    assign wr_me   = reg_wr && st_hit && (idx == SB'(i));
    assign blocked = lock && me;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        st_q   <= '{th: '0, ok: 1'b0, unr: 1'b0, own: 1'b1, len: '0};
        pend_q <= 1'b0;
        base_q <= '0;
      end else begin
        if (reg_wr && ad_hit && (idx == SB'(i))) base_q <= reg_wdata;
        if (wr_me && !blocked) begin
          st_q.len <= reg_wdata[LEN_W-1:0];
          st_q.th  <= reg_wdata[16 +: TH_W];
          st_q.own <= 1'b0;
          st_q.unr <= 1'b0;
          st_q.ok  <= 1'b0;
          pend_q   <= 1'b1;
        end else if (me) begin
          if (ev_start)   pend_q   <= 1'b0;
          if (ev_fetched) st_q.own <= 1'b1;
          if (ev_ok)      st_q.ok  <= 1'b1;
          if (ev_unr)     st_q.unr <= 1'b1;
        end
      end
    end

    assign st_w[i]   = st_q;
    assign base_w[i] = base_q;
    assign pend_o[i] = pend_q;
    assign len_o[i]  = st_q.len;
    assign th_o[i]   = st_q.th;
    assign base_o[i] = base_q;

    // R10: a write to the slot in service leaves its length untouched
    a_r10_locked: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_me && blocked) |=> $stable(st_q.len));
  end

  // Sticky interrupt flags, write-one-to-clear.
  logic ok_irq_q, err_irq_q;
  logic clr_ok, clr_err;

  assign clr_ok  = reg_wr && ir_hit && reg_wdata[OK_IBIT];
  assign clr_err = reg_wr && ir_hit && reg_wdata[ERR_IBIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ok_irq_q  <= 1'b0;
      err_irq_q <= 1'b0;
    end else begin
      ok_irq_q  <= ev_ok  | (ok_irq_q  & ~clr_ok);
      err_irq_q <= ev_unr | (err_irq_q & ~clr_err);
    end
  end

  assign irq = ok_irq_q | err_irq_q;

  always_comb begin
    reg_rdata = '0;
    if (st_hit)      reg_rdata = pack_status(st_w[idx]);
    else if (ad_hit) reg_rdata = base_w[idx];
    else if (ir_hit) begin
      reg_rdata[OK_IBIT]  = ok_irq_q;
      reg_rdata[ERR_IBIT] = err_irq_q;
    end
  end

  // R7: good completion raises the OK flag
  a_r7_ok_irq: assert property (@(posedge clk) disable iff (!rst_n)
    ev_ok |=> ok_irq_q);
  // R8: underrun raises the error flag
  a_r8_err_irq: assert property (@(posedge clk) disable iff (!rst_n)
    ev_unr |=> err_irq_q);

endmodule

// File: rtl/txd_ctrl.sv
module txd_ctrl
  import txd_pkg::*;
#(
  parameter int NSLOT = 4,
  parameter int DEPTH = 64,
  localparam int SB    = (NSLOT > 1) ? $clog2(NSLOT) : 1,
  localparam int CNT_W = $clog2(DEPTH) + 1
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NSLOT-1:0]            pend,
  input  logic [NSLOT-1:0][LEN_W-1:0] lens,
  input  logic [NSLOT-1:0][TH_W-1:0]  ths,
  input  logic [NSLOT-1:0][31:0]      bases,
  output logic                        mem_req,
  output logic [31:0]                 mem_addr,
  input  logic                        mem_gnt,
  input  logic [CNT_W-1:0]            fifo_cnt,
  input  logic                        fifo_empty,
  input  logic                        fifo_full,
  input  logic [7:0]                  fifo_dout,
  output logic                        fifo_push,
  output logic                        fifo_pop,
  output logic                        fifo_flush,
  output logic                        tx_valid,
  output logic [7:0]                  tx_data,
  output logic                        tx_last,
  input  logic                        tx_ready,
  output logic                        lock,
  output logic [SB-1:0]               act_slot,
  output logic                        ev_start,
  output logic                        ev_fetched,
  output logic                        ev_ok,
  output logic                        ev_unr
);

  logic             busy_q, stream_q;
  logic [SB-1:0]    cur_q, cur_nx;
  logic [31:0]      base_q;
  logic [LEN_W-1:0] len_q, fetched_q, sent_q;
  logic [15:0]      eth_q;
  logic             all_fetched, zero_len, start_ok;

  assign cur_nx      = (cur_q == SB'(NSLOT - 1)) ? '0 : cur_q + 1'b1;
  assign all_fetched = (fetched_q == len_q);
  assign zero_len    = busy_q && (len_q == '0);

  assign ev_start = !busy_q && pend[cur_q];
  assign lock     = busy_q || pend[cur_q];
  assign act_slot = cur_q;

  assign mem_req    = busy_q && !all_fetched && !fifo_full;
  assign mem_addr   = base_q + 32'(fetched_q);
  assign fifo_push  = mem_req && mem_gnt;
  assign ev_fetched = (fifo_push && (fetched_q + 1'b1 == len_q)) || zero_len;

  assign tx_valid = busy_q && stream_q && !fifo_empty;
  assign tx_data  = fifo_dout;
  assign tx_last  = tx_valid && (sent_q + 1'b1 == len_q);
  assign fifo_pop = tx_valid && tx_ready;

  assign ev_ok      = (fifo_pop && tx_last) || zero_len;
  assign ev_unr     = busy_q && stream_q && tx_ready && fifo_empty && (sent_q != len_q);
  assign fifo_flush = ev_unr;

  assign start_ok = (16'(fifo_cnt) >= eth_q) || all_fetched;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q    <= 1'b0;
      stream_q  <= 1'b0;
      cur_q     <= '0;
      base_q    <= '0;
      len_q     <= '0;
      fetched_q <= '0;
      sent_q    <= '0;
      eth_q     <= 16'd1;
    end else if (!busy_q) begin
      if (pend[cur_q]) begin
        busy_q    <= 1'b1;
        stream_q  <= 1'b0;
        base_q    <= bases[cur_q];
        len_q     <= lens[cur_q];
        eth_q     <= eff_thresh(ths[cur_q], DEPTH);
        fetched_q <= '0;
        sent_q    <= '0;
      end else begin
        cur_q <= cur_nx;
      end
    end else begin
      if (fifo_push) fetched_q <= fetched_q + 1'b1;
      if (fifo_pop)  sent_q    <= sent_q + 1'b1;
      if (!stream_q && start_ok) stream_q <= 1'b1;
      if (ev_ok || ev_unr) begin
        busy_q <= 1'b0;
        cur_q  <= cur_nx;
      end
    end
  end

  // R5: an offered byte holds until taken
  a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data) && $stable(tx_last)));
  // R4: streaming opens only at the threshold or on full fetch
  a_r4_threshold: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stream_q) |-> ((16'(fifo_cnt) >= eth_q) || all_fetched));
  // R7 R8: a frame ends one way only
  a_r7_one_outcome: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ev_ok, ev_unr}));
  // R9: after a frame ends the engine returns to scanning
  a_r9_release: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_ok || ev_unr) |=> !busy_q);

endmodule

// File: rtl/txdesc_engine.sv
module txdesc_engine
  import txd_pkg::*;
#(
  parameter int NSLOT      = 4,
  parameter int FIFO_DEPTH = 64
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic [7:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        irq,
  output logic        mem_req,
  output logic [31:0] mem_addr,
  input  logic        mem_gnt,
  input  logic [7:0]  mem_rdata,
  output logic        tx_valid,
  output logic [7:0]  tx_data,
  output logic        tx_last,
  input  logic        tx_ready
);

  localparam int SB    = (NSLOT > 1) ? $clog2(NSLOT) : 1;
  localparam int CNT_W = $clog2(FIFO_DEPTH) + 1;

  logic [NSLOT-1:0]            pend;
  logic [NSLOT-1:0][LEN_W-1:0] lens;
  logic [NSLOT-1:0][TH_W-1:0]  ths;
  logic [NSLOT-1:0][31:0]      bases;
  logic                        lock, ev_start, ev_fetched, ev_ok, ev_unr;
  logic [SB-1:0]               act_slot;
  logic                        f_push, f_pop, f_flush, f_empty, f_full;
  logic [CNT_W-1:0]            f_cnt;
  logic [7:0]                  f_dout;

  txd_regs #(.NSLOT(NSLOT), .AW(8)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq(irq),
    .lock(lock), .lock_slot(act_slot), .ev_start(ev_start),
    .ev_fetched(ev_fetched), .ev_ok(ev_ok), .ev_unr(ev_unr),
    .pend_o(pend), .len_o(lens), .th_o(ths), .base_o(bases)
  );

  txd_fifo #(.DEPTH(FIFO_DEPTH), .W(8)) u_fifo (
    .clk(clk), .rst_n(rst_n),
    .push(f_push), .pop(f_pop), .flush(f_flush), .din(mem_rdata),
    .dout(f_dout), .count(f_cnt), .empty(f_empty), .full(f_full)
  );

  txd_ctrl #(.NSLOT(NSLOT), .DEPTH(FIFO_DEPTH)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .pend(pend), .lens(lens), .ths(ths), .bases(bases),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_gnt(mem_gnt),
    .fifo_cnt(f_cnt), .fifo_empty(f_empty), .fifo_full(f_full), .fifo_dout(f_dout),
    .fifo_push(f_push), .fifo_pop(f_pop), .fifo_flush(f_flush),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_last(tx_last), .tx_ready(tx_ready),
    .lock(lock), .act_slot(act_slot), .ev_start(ev_start),
    .ev_fetched(ev_fetched), .ev_ok(ev_ok), .ev_unr(ev_unr)
  );

endmodule

// File: tb/sim_txdesc_engine.sv
module sim_txdesc_engine;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [7:0]  reg_addr = 8'h00;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq, mem_req, mem_gnt, tx_valid, tx_last, tx_ready;
  logic [31:0] mem_addr;
  logic [7:0]  mem_rdata, tx_data;

  always #2 clk = ~clk;

  txdesc_engine u0 (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_gnt(mem_gnt), .mem_rdata(mem_rdata),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_last(tx_last), .tx_ready(tx_ready)
  );

  function automatic logic [7:0] mem_byte(input logic [31:0] a);
    return a[7:0] ^ a[15:8] ^ 8'hA5;
  endfunction
  assign mem_rdata = mem_byte(mem_addr);

  int checks = 0, errors = 0, cyc = 0;
  int gmode = 0, rmode = 0;

  // Reference model: queue of expected frames, walked byte by byte
  int fq_base[$], fq_len[$], fq_lo[$], fq_hi[$];
  int pushes = 0, sent = 0;
  bit first_seen = 0;
  bit prv_hold = 0;
  logic [7:0] prv_data;
  logic prv_last;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] stw(input int len, input int th, input int own,
                                      input int unr, input int ok);
    return 32'(th * 65536 + ok * 32768 + unr * 16384 + own * 8192 + len);
  endfunction

  task automatic expect_frame(input int base, input int len, input int lo, input int hi);
    fq_base.push_back(base); fq_len.push_back(len);
    fq_lo.push_back(lo);     fq_hi.push_back(hi);
  endtask

  always @(negedge clk) begin
    cyc++;
    mem_gnt  = (gmode == 0) ? 1'b1 : (cyc % 4 == 0);
    tx_ready = (rmode == 0) ? 1'b1 : (rmode == 1) ? (cyc % 3 != 0) : 1'b0;
  end

  always @(negedge clk) begin
    #1;
    if (rst_n) begin
      if (prv_hold) begin
        chk("R5 hold valid", 32'(tx_valid), 32'd1);
        chk("R5 hold data", {24'b0, tx_data}, {24'b0, prv_data});
        chk("R5 hold last", 32'(tx_last), 32'(prv_last));
      end
      prv_hold = tx_valid && !tx_ready;
      prv_data = tx_data;
      prv_last = tx_last;
      if (tx_valid && !first_seen && fq_len.size() > 0) begin
        checks++;
        if (pushes < fq_lo[0] || pushes > fq_hi[0]) begin
          errors++;
          $display("FAIL R4 start point: actual=%0d expected=%0d..%0d", pushes, fq_lo[0], fq_hi[0]);
        end
        first_seen = 1;
      end
      if (mem_req && mem_gnt) begin
        if (fq_len.size() > 0)
          chk("R3 R9 fetch address", mem_addr, 32'(fq_base[0] + pushes));
        pushes++;
      end
      if (tx_valid && tx_ready) begin
        if (fq_len.size() == 0) begin
          checks++; errors++;
          $display("FAIL R10 unexpected byte: actual=%h expected=none", tx_data);
        end else begin
          chk("R5 R9 data", {24'b0, tx_data}, {24'b0, mem_byte(32'(fq_base[0] + sent))});
          chk("R5 last", 32'(tx_last), 32'(sent == fq_len[0] - 1));
          sent++;
          if (sent == fq_len[0]) begin
            void'(fq_base.pop_front()); void'(fq_len.pop_front());
            void'(fq_lo.pop_front());   void'(fq_hi.pop_front());
            sent = 0; pushes = 0; first_seen = 0;
          end
        end
      end
    end
  end

  always @(posedge clk) begin
    if (cyc > 60000) begin
      errors++;
      $display("FAIL watchdog: actual=%0d expected<60000", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wait_done();
    for (int i = 0; i < 5000 && fq_len.size() != 0; i++) @(negedge clk);
    chk("R9 all frames sent", 32'(fq_len.size()), 32'd0);
    idle(4);
  endtask

  logic [31:0] v;

  initial begin
    idle(3);
    // R1: reset state
    for (int s = 0; s < 4; s++) begin
      rd(8'(4 * s), v);        chk("R1 status reset", v, 32'h0000_2000);
      rd(8'(16 + 4 * s), v);   chk("R1 address reset", v, 32'h0);
    end
    rst_n = 1'b1;
    rd(8'h20, v); chk("R1 interrupt reset", v, 32'h0);
    chk("R1 irq low", 32'(irq), 32'd0);
    chk("R1 no valid", 32'(tx_valid), 32'd0);
    chk("R1 no request", 32'(mem_req), 32'd0);

    // Single frame, slot 0, threshold 1 (32 bytes)
    wr(8'h10, 32'h0000_1000);
    rd(8'h10, v); chk("R2 address readback", v, 32'h0000_1000);
    expect_frame(32'h1000, 64, 32, 33);
    wr(8'h00, stw(64, 1, 1, 1, 1));
    rd(8'h00, v); chk("R2 status after write", v, stw(64, 1, 0, 0, 0));
    wait_done();
    rd(8'h00, v); chk("R6 R7 slot0 done", v, stw(64, 1, 1, 0, 1));
    rd(8'h20, v); chk("R7 ok flag", v, 32'h4);
    chk("R11 irq high", 32'(irq), 32'd1);
    wr(8'h20, 32'h4);
    rd(8'h20, v); chk("R11 ok flag cleared", v, 32'h0);
    chk("R11 irq low", 32'(irq), 32'd0);

    // Round robin with skip, lock, and a stalling MAC
    rmode = 1;
    wr(8'h18, 32'h0000_2000);
    wr(8'h10, 32'h0000_5000);
    wr(8'h14, 32'h0000_6000);
    expect_frame(32'h2000, 100, 64, 65);
    expect_frame(32'h5000, 80, 64, 65);
    expect_frame(32'h6000, 60, 60, 61);
    wr(8'h08, stw(100, 2, 0, 0, 0));
    idle(12);
    wr(8'h08, stw(5, 0, 0, 0, 0));   // R10: slot 2 is in service
    wr(8'h00, stw(80, 3, 0, 0, 0));
    wr(8'h04, stw(60, 63, 0, 0, 0));
    wait_done();
    idle(30);
    rd(8'h08, v); chk("R10 slot2 unchanged", v, stw(100, 2, 1, 0, 1));
    rd(8'h00, v); chk("R7 slot0 done", v, stw(80, 3, 1, 0, 1));
    rd(8'h04, v); chk("R7 slot1 done", v, stw(60, 63, 1, 0, 1));
    rd(8'h0C, v); chk("R9 slot3 untouched", v, 32'h0000_2000);
    rd(8'h20, v); chk("R7 ok flag again", v, 32'h4);
    wr(8'h20, 32'h4);

    // Host-owns set on full fetch before the MAC takes anything
    rmode = 2;
    wr(8'h1C, 32'h0000_3000);
    expect_frame(32'h3000, 60, 60, 61);
    wr(8'h0C, stw(60, 63, 0, 0, 0));
    idle(120);
    rd(8'h0C, v); chk("R6 own before ok", v, stw(60, 63, 1, 0, 0));
    chk("R4 R5 valid waiting", 32'(tx_valid), 32'd1);
    rmode = 0;
    wait_done();
    rd(8'h0C, v); chk("R7 slot3 done", v, stw(60, 63, 1, 0, 1));
    wr(8'h20, 32'h4);

    // Underrun: slow grants, always-ready MAC, threshold 0
    gmode = 1;
    wr(8'h10, 32'h0000_4000);
    expect_frame(32'h4000, 64, 1, 64);
    wr(8'h00, stw(64, 0, 0, 0, 0));
    idle(200);
    rd(8'h00, v); chk("R8 underrun status", v, stw(64, 0, 0, 1, 0));
    rd(8'h20, v); chk("R8 error flag", v, 32'h8);
    chk("R8 irq high", 32'(irq), 32'd1);
    chk("R8 partial frame", 32'(sent >= 1 && sent < 64), 32'd1);
    fq_base.delete(); fq_len.delete(); fq_lo.delete(); fq_hi.delete();
    sent = 0; pushes = 0; first_seen = 0;
    gmode = 0;
    idle(30);
    chk("R8 frame dropped", 32'(tx_valid), 32'd0);
    wr(8'h20, 32'h8);
    rd(8'h20, v); chk("R11 error flag cleared", v, 32'h0);
    chk("R11 irq low after clear", 32'(irq), 32'd0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule